// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block governs how a control computer comes back after its supply disappears or after its front-panel ON/OFF pushbutton is cycled. It times every supply outage with a millisecond tick. A dropout of up to 20 ms is ridden through with no visible effect. A longer outage takes the computer down. When supply and the pushbutton both allow it again, the block picks either a short or a long self-test. The choice depends on how long the outage lasted and on whether any of the three hydraulic systems is pressurized.

The selected test list is run one test at a time over a start/done/pass handshake with external test engines. Each step has a timeout, and the short list as a whole has a 1.5 s budget. The block ends in a ready state when every step passes and in a fault state otherwise. Either state is held until the computer is next taken down.

Top module: `pst_powerup_seq`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `busy`, `ready`, `fault` and `test_start` are all low. Reset counts as a cold start: the first start then behaves as if the outage had been long.
- R2: A supply loss that spans at most 20 consecutive `ms_tick` pulses changes no output and does not restart or interrupt a running or finished sequence. The outage count restarts from zero whenever supply returns.
- R3: At the 21st `ms_tick` of one continuous outage the computer goes down. From the next cycle, `busy`, `ready` and `fault` are low and no test is strobed until a restart.
- R4: A restart after a down outage runs the short list whenever at least one bit of `hyd_high` is set in the start cycle.
- R5: With all `hyd_high` bits low at restart, an outage of fewer than 3000 ticks selects the short list and an outage of 3000 ticks or more selects the long list.
- R6: `pb_on` low takes the computer down and marks a cold start. The cycle after `pb_on` is high with supply present, a sequence starts: the short list if any hydraulic bit is high, otherwise the long list.
- R7: Test identifiers on `test_id` are: processor 0, watchdog 1, checksum 2, full RAM 3, timer 4, interrupt 5, bus error 6, partial RAM 7. The short list is 4, 5, 7. The long list is 0, 1, 2, 3, 4, 5, 6, in that order.
- R8: Each step raises `test_start` for exactly one cycle with its `test_id`. A `test_done` with `test_pass` high while waiting strobes the next step in the following cycle. `busy` is high from the first strobe until the sequence ends.
- R9: When the last step passes, `ready` rises in the next cycle with `busy` low. It holds until the computer goes down.
- R10: A `test_done` with `test_pass` low sets `fault`, keeps `ready` low and strobes no further test. `fault` holds until the computer goes down.
- R11: If 1000 ticks pass while one step waits for `test_done`, the step counts as failed and `fault` is set.
- R12: If a short sequence is still running at the 1500th tick after its start, `fault` is set. A long sequence has no overall budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| supply_ok | input | 1 | High while the supply is present |
| pb_on | input | 1 | Pushbutton state, high for ON |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| hyd_high | input | 3 | One bit per hydraulic system, high when pressurized |
| test_done | input | 1 | Pulse from the test engine when the current test ends |
| test_pass | input | 1 | Result qualifying `test_done`, high for pass |
| test_start | output | 1 | One-cycle strobe launching a test |
| test_id | output | 3 | Identifier of the test being launched |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | All tests of the sequence passed |
| fault | output | 1 | A test failed or timed out |

## Verification
The bench targets the edges of the outage thresholds. It uses dropouts of exactly 20 and 21 ticks: a design off by one would restart on the first or ride through the second. It uses outages of 2999 and 3000 ticks with no hydraulic pressure, where a wrong comparison would choose the wrong list. It also restarts with pressure present, and cycles the pushbutton with and without pressure, catching a design that ignores the hydraulic override or the pushbutton's cold-start rule. On the failure side, it fails a mid-list step, hangs a step until the 1000-tick timeout, and stretches a short sequence past its 1500-tick budget. A missing check there would show `ready` instead of `fault`. It also runs a slow long list that must still pass, catching a budget wrongly applied to both lists.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int TID_W = 3;
  localparam int IDX_W = 3;
  localparam int SHORT_STEPS = 3;
  localparam int LONG_STEPS  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_READY,
    ST_FAULT
  } seq_state_t;

  localparam logic [TID_W-1:0] TID_CPU      = 3'd0;
  localparam logic [TID_W-1:0] TID_WDOG     = 3'd1;
  localparam logic [TID_W-1:0] TID_CSUM     = 3'd2;
  localparam logic [TID_W-1:0] TID_RAM_FULL = 3'd3;
  localparam logic [TID_W-1:0] TID_TIMER    = 3'd4;
  localparam logic [TID_W-1:0] TID_IRQ      = 3'd5;
  localparam logic [TID_W-1:0] TID_BUSERR   = 3'd6;
  localparam logic [TID_W-1:0] TID_RAM_PART = 3'd7;
endpackage

// File: rtl/pst_outage_mon.sv
// Times supply outages on the millisecond tick and keeps the down and
// cold-start flags that decide when and how the computer restarts.
module pst_outage_mon #(
  parameter int RIDE_MS = 20,
  parameter int LONG_MS = 3000,
  parameter int CNT_W   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pb_on,
  input  logic ms_tick,
  input  logic start_go,
  output logic down_q,
  output logic cold_q
);
  localparam logic [CNT_W-1:0] RIDE_LIM = CNT_W'(RIDE_MS);
  localparam logic [CNT_W-1:0] LONG_LIM = CNT_W'(LONG_MS);
  localparam logic [CNT_W-1:0] LONG_PRE = CNT_W'(LONG_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_d, cold_d;
  logic             gap_tick;
  logic             cnt_en;

  assign gap_tick = !supply_ok && ms_tick;
  assign cnt_en   = supply_ok || (ms_tick && (cnt_q != LONG_LIM));

  always_comb begin
    cnt_d = cnt_q;
    if (supply_ok) begin
      cnt_d = '0;
    end else if (ms_tick && (cnt_q != LONG_LIM)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    down_d = down_q;
    cold_d = cold_q;
    if (start_go) begin
      down_d = 1'b0;
      cold_d = 1'b0;
    end
    // Tick number RIDE_MS+1 of one outage is beyond the ride-through window.
    if (gap_tick && (cnt_q >= RIDE_LIM)) begin
      down_d = 1'b1;
    end
    if (gap_tick && (cnt_q >= LONG_PRE)) begin
      cold_d = 1'b1;
    end
    if (!pb_on) begin
      down_d = 1'b1;
      cold_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_q <= 1'b1;
      cold_q <= 1'b1;
    end else begin
      down_q <= down_d;
      cold_q <= cold_d;
    end
  end
endmodule

// File: rtl/pst_step_rom.sv
// Maps a step index of the selected list onto a test identifier.
module pst_step_rom
  import pst_pkg::*;
(
  input  logic             long_sel,
  input  logic [IDX_W-1:0] idx,
  output logic [TID_W-1:0] tid,
  output logic             last
);
  always_comb begin
    tid = TID_CPU;
    if (long_sel) begin
      case (idx)
        3'd0:    tid = TID_CPU;
        3'd1:    tid = TID_WDOG;
        3'd2:    tid = TID_CSUM;
        3'd3:    tid = TID_RAM_FULL;
        3'd4:    tid = TID_TIMER;
        3'd5:    tid = TID_IRQ;
        default: tid = TID_BUSERR;
      endcase
      last = (idx == IDX_W'(LONG_STEPS - 1));
    end else begin
      case (idx)
        3'd0:    tid = TID_TIMER;
        3'd1:    tid = TID_IRQ;
        default: tid = TID_RAM_PART;
      endcase
      last = (idx == IDX_W'(SHORT_STEPS - 1));
    end
  end
endmodule

// File: rtl/pst_sequencer.sv
// Steps through the chosen list over the start/done/pass handshake,
// with a per-step timeout and an overall budget for the short list.
module pst_sequencer
  import pst_pkg::*;
#(
  parameter int STEP_TO_MS = 1000,
  parameter int BUDGET_MS  = 1500,
  parameter int STO_W      = 10,
  parameter int BUD_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             start_go,
  input  logic             go_long,
  input  logic             abort,
  input  logic             test_done,
  input  logic             test_pass,
  input  logic             step_last,
  output logic [IDX_W-1:0] idx_q,
  output logic             long_q,
  output logic             test_start,
  output logic             busy,
  output logic             ready,
  output logic             fault
);
  localparam logic [STO_W-1:0] STO_LAST = STO_W'(STEP_TO_MS - 1);
  localparam logic [BUD_W-1:0] BUD_LAST = BUD_W'(BUDGET_MS - 1);

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_d;
  logic             long_d;
  logic [STO_W-1:0] step_q, step_d;
  logic [BUD_W-1:0] tot_q, tot_d;
  logic             sto_hit, bud_hit, in_run;
  logic             cnt_en;

  assign in_run  = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
  assign sto_hit = ms_tick && (step_q == STO_LAST);
  assign bud_hit = ms_tick && !long_q && (tot_q == BUD_LAST);
  assign cnt_en  = start_go || in_run;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    long_d = long_q;
    step_d = step_q;
    tot_d  = tot_q;
    if (in_run && ms_tick) begin
      tot_d = tot_q + 1'b1;
    end
    if (start_go) begin
      st_d   = ST_ISSUE;
      idx_d  = '0;
      long_d = go_long;
      tot_d  = '0;
    end else if (abort) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_ISSUE: begin
          step_d = '0;
          st_d   = bud_hit ? ST_FAULT : ST_WAIT;
        end
        ST_WAIT: begin
          if (ms_tick) begin
            step_d = step_q + 1'b1;
          end
          if (test_done) begin
            if (!test_pass) begin
              st_d = ST_FAULT;
            end else if (step_last) begin
              st_d = ST_READY;
            end else begin
              idx_d = idx_q + 1'b1;
              st_d  = ST_ISSUE;
            end
          end else if (sto_hit || bud_hit) begin
            st_d = ST_FAULT;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      long_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      long_q <= long_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      tot_q  <= '0;
    end else if (cnt_en) begin
      step_q <= step_d;
      tot_q  <= tot_d;
    end
  end

  assign test_start = (st_q == ST_ISSUE);
  assign busy       = in_run;
  assign ready      = (st_q == ST_READY);
  assign fault      = (st_q == ST_FAULT);
endmodule

// File: rtl/pst_powerup_seq.sv
module pst_powerup_seq
  import pst_pkg::*;
#(
  parameter int RIDE_MS    = 20,
  parameter int LONG_MS    = 3000,
  parameter int BUDGET_MS  = 1500,
  parameter int STEP_TO_MS = 1000,
  parameter int HYD_N      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             pb_on,
  input  logic             ms_tick,
  input  logic [HYD_N-1:0] hyd_high,
  input  logic             test_done,
  input  logic             test_pass,
  output logic             test_start,
  output logic [TID_W-1:0] test_id,
  output logic             busy,
  output logic             ready,
  output logic             fault
);
  localparam int OUT_W = $clog2(LONG_MS + 1);
  localparam int STO_W = $clog2(STEP_TO_MS + 1);
  localparam int BUD_W = $clog2(BUDGET_MS + 1);

  logic             down_q, cold_q;
  logic             start_go, go_long;
  logic [IDX_W-1:0] idx_q;
  logic             long_q, step_last;

  assign start_go = down_q && supply_ok && pb_on;
  assign go_long  = cold_q && !(|hyd_high);

  pst_outage_mon #(
    .RIDE_MS(RIDE_MS),
    .LONG_MS(LONG_MS),
    .CNT_W  (OUT_W)
  ) u_outage (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .pb_on    (pb_on),
    .ms_tick  (ms_tick),
    .start_go (start_go),
    .down_q   (down_q),
    .cold_q   (cold_q)
  );

  pst_step_rom u_rom (
    .long_sel(long_q),
    .idx     (idx_q),
    .tid     (test_id),
    .last    (step_last)
  );

  pst_sequencer #(
    .STEP_TO_MS(STEP_TO_MS),
    .BUDGET_MS (BUDGET_MS),
    .STO_W     (STO_W),
    .BUD_W     (BUD_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .start_go  (start_go),
    .go_long   (go_long),
    .abort     (down_q),
    .test_done (test_done),
    .test_pass (test_pass),
    .step_last (step_last),
    .idx_q     (idx_q),
    .long_q    (long_q),
    .test_start(test_start),
    .busy      (busy),
    .ready     (ready),
    .fault     (fault)
  );
endmodule

// File: rtl/pst_powerup_seq_chk.sv
module pst_powerup_seq_chk #(
  parameter int RIDE_MS = 20
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic pb_on,
  input logic ms_tick,
  input logic test_done,
  input logic test_pass,
  input logic test_start,
  input logic busy,
  input logic ready,
  input logic fault,
  input logic down_q
);
  logic [15:0] gap_q;

  // Independent count of ticks in the current outage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (supply_ok) begin
      gap_q <= '0;
    end else if (ms_tick && (gap_q != 16'hffff)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_ride_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!down_q && pb_on && (supply_ok || !ms_tick || (gap_q < 16'(RIDE_MS)))) |=> !down_q);

  assert_down_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (down_q && !(supply_ok && pb_on)) |=> (!busy && !ready && !fault));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_start && !down_q) |=> !test_start);

  assert_pass_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !test_start && test_done && test_pass && !down_q) |=> (test_start || ready));

  assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !down_q) |=> ready);

  assert_fault_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !down_q) |=> fault);

  assert_fail_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !test_start && test_done && !test_pass && !down_q) |=> (fault && !test_start));

  assert_states_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ready, fault}));
endmodule

bind pst_powerup_seq pst_powerup_seq_chk #(.RIDE_MS(RIDE_MS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .pb_on     (pb_on),
  .ms_tick   (ms_tick),
  .test_done (test_done),
  .test_pass (test_pass),
  .test_start(test_start),
  .busy      (busy),
  .ready     (ready),
  .fault     (fault),
  .down_q    (down_q)
);

// File: tb/pst_powerup_seq_test.sv
`timescale 1ns/1ps
module pst_powerup_seq_test;
  localparam int RIDE     = 20;
  localparam int LONGO    = 3000;
  localparam int BUDGET   = 1500;
  localparam int STO      = 1000;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, pb_on, ms_tick, test_done, test_pass;
  logic [2:0] hyd_high;
  logic test_start, busy, ready, fault;
  logic [2:0] test_id;

  always #2 clk = ~clk;

  pst_powerup_seq uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pb_on(pb_on),
    .ms_tick(ms_tick), .hyd_high(hyd_high), .test_done(test_done),
    .test_pass(test_pass), .test_start(test_start), .test_id(test_id),
    .busy(busy), .ready(ready), .fault(fault)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic int list_len(bit lg);
    return lg ? 7 : 3;
  endfunction

  function automatic int list_id(bit lg, int i);
    int s[3] = '{4, 5, 7};
    int l[7] = '{0, 1, 2, 3, 4, 5, 6};
    return lg ? l[i] : s[i];
  endfunction

  // Behavioural reference: 0 idle, 1 issue, 2 wait, 3 ready, 4 fault
  int m_out, m_st, m_idx, m_step, m_tot;
  bit m_down, m_cold, m_long;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_st = 0; m_idx = 0; m_step = 0; m_tot = 0;
      m_down = 1; m_cold = 1; m_long = 0;
    end else begin
      bit start, bud, sto, was_run;
      start   = m_down && supply_ok && pb_on;
      bud     = ms_tick && !m_long && (m_tot == BUDGET - 1);
      sto     = ms_tick && (m_step == STO - 1);
      was_run = (m_st == 1) || (m_st == 2);
      if (start) begin
        m_long = m_cold && (hyd_high == 3'b000);
        m_st = 1; m_idx = 0; m_tot = 0;
      end else begin
        if (was_run && ms_tick) m_tot++;
        if (m_down) m_st = 0;
        else if (m_st == 1) begin
          m_step = 0;
          m_st = bud ? 4 : 2;
        end else if (m_st == 2) begin
          if (test_done) begin
            if (!test_pass) m_st = 4;
            else if (m_idx == list_len(m_long) - 1) m_st = 3;
            else begin m_idx++; m_st = 1; end
          end else if (sto || bud) m_st = 4;
          else if (ms_tick) m_step++;
        end
      end
      if (supply_ok) m_out = 0;
      else if (ms_tick) begin
        if (m_out < LONGO) m_out++;
        if (m_out > RIDE) m_down = 1;
        if (m_out >= LONGO) m_cold = 1;
      end
      if (!pb_on) begin m_down = 1; m_cold = 1; end
      if (start) begin m_down = 0; m_cold = 0; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Responder state
  int resp_ms = 2;
  int fail_at = -1;
  bit hang = 0;
  bit pend = 0;
  int left = 0;
  int tick_ctr = 0;
  int seen[$];

  task automatic cyc();
    @(negedge clk);
    chk("R8 busy vs model", int'(busy), int'((m_st == 1) || (m_st == 2)));
    chk("R8 test_start vs model", int'(test_start), int'(m_st == 1));
    chk("R9 ready vs model", int'(ready), int'(m_st == 3));
    chk("R10 fault vs model", int'(fault), int'(m_st == 4));
    if (m_st == 1) chk("R7 test_id vs model", int'(test_id), list_id(m_long, m_idx));
    test_done = 1'b0;
    test_pass = 1'b0;
    if (test_start) begin
      seen.push_back(int'(test_id));
      if (!hang) begin pend = 1; left = resp_ms * TICK_DIV; end
    end else if (pend) begin
      if (left == 0) begin
        test_done = 1'b1;
        test_pass = (fail_at != seen.size() - 1);
        pend = 0;
      end else left--;
    end
    ms_tick = (tick_ctr == 0);
    tick_ctr = (tick_ctr + 1) % TICK_DIV;
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic clr();
    seen.delete();
    pend = 0;
  endtask

  // Supply low for exactly ms ticks, then two more tick-free cycles.
  task automatic drop(int ms);
    int n;
    supply_ok = 1'b0;
    n = ms_tick ? 1 : 0;
    while (n < ms) begin
      cyc();
      if (ms_tick) n++;
    end
    cyc();
    cyc();
  endtask

  task automatic restore();
    supply_ok = 1'b1;
  endtask

  task automatic pb_cycle();
    pb_on = 1'b0;
    run(3);
    clr();
    pb_on = 1'b1;
  endtask

  task automatic expect_ids(string tag, bit lg);
    chk({tag, " step count"}, seen.size(), list_len(lg));
    for (int i = 0; i < seen.size() && i < list_len(lg); i++)
      chk({tag, " id order"}, seen[i], list_id(lg, i));
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; pb_on = 1'b1; ms_tick = 1'b0;
    hyd_high = 3'b000; test_done = 1'b0; test_pass = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 ready after reset", int'(ready), 0);
    chk("R1 fault after reset", int'(fault), 0);
    chk("R1 test_start after reset", int'(test_start), 0);

    // Power-on is a cold start: long list, no pressure.
    restore();
    run(300);
    expect_ids("R1 R7 cold start long list", 1);
    chk("R9 ready after long list", int'(ready), 1);
    chk("R8 busy after long list", int'(busy), 0);

    clr(); drop(20);
    chk("R2 ready during 20-tick dropout", int'(ready), 1);
    restore(); run(20);
    chk("R2 ready after 20-tick dropout", int'(ready), 1);
    chk("R2 no restart strobes", seen.size(), 0);

    clr(); drop(21);
    chk("R3 ready after 21 ticks", int'(ready), 0);
    chk("R3 busy after 21 ticks", int'(busy), 0);
    chk("R3 fault after 21 ticks", int'(fault), 0);
    hyd_high = 3'b001;
    restore(); run(150);
    expect_ids("R4 pressure restart short list", 0);
    chk("R4 ready", int'(ready), 1);

    hyd_high = 3'b000;
    clr(); drop(100); restore(); run(150);
    expect_ids("R5 100-tick unpressurized short", 0);
    clr(); drop(2999); restore(); run(150);
    expect_ids("R5 2999-tick short", 0);
    clr(); drop(3000); restore(); run(300);
    expect_ids("R5 3000-tick long", 1);
    chk("R5 ready after long", int'(ready), 1);

    pb_on = 1'b0; run(3);
    chk("R6 ready with pushbutton off", int'(ready), 0);
    chk("R6 busy with pushbutton off", int'(busy), 0);
    clr(); hyd_high = 3'b010; pb_on = 1'b1; run(150);
    expect_ids("R6 pushbutton with pressure short", 0);
    hyd_high = 3'b000;
    pb_cycle(); run(300);
    expect_ids("R6 pushbutton unpressurized long", 1);

    hyd_high = 3'b001; fail_at = 1;
    pb_cycle(); run(150);
    chk("R10 fault after failed step", int'(fault), 1);
    chk("R10 ready after failed step", int'(ready), 0);
    chk("R10 strobes stop after failure", seen.size(), 2);
    fail_at = -1;

    hang = 1;
    pb_cycle(); run(3960);
    chk("R11 no fault before timeout", int'(fault), 0);
    chk("R8 busy while waiting", int'(busy), 1);
    run(80);
    chk("R11 fault after step timeout", int'(fault), 1);
    chk("R11 busy after step timeout", int'(busy), 0);
    hang = 0;

    resp_ms = 700;
    pb_cycle(); run(6100);
    chk("R12 fault on short budget", int'(fault), 1);
    chk("R12 ready on short budget", int'(ready), 0);
    chk("R12 steps reached", seen.size(), 3);
    hyd_high = 3'b000;
    pb_cycle(); run(20000);
    chk("R12 slow long list ready", int'(ready), 1);
    chk("R12 slow long list fault", int'(fault), 0);
    expect_ids("R12 slow long list", 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule